// File: doc/BRIEF.md
# DSSS Preamble and Header Bit Framer

This block produces the serial bit stream that precedes every frame in a direct-sequence wireless LAN physical layer. After a start request it sends a synchronisation run, a 16-bit start-of-frame delimiter, a 32-bit header and a 16-bit CRC over that header. It then raises a done pulse that tells the payload path its bits may follow. Two formats are supported. The long format has a 128-bit sync run. The short format has a 56-bit sync run and a different delimiter. Both formats use the same header layout.

A bit-clock enable paces the stream, and every output register moves only on an enable cycle. The rate code, the format select and the 16-bit length are captured when a start request is accepted. Later changes to those inputs do not affect the frame in flight. Scrambling, spreading and payload handling belong to neighbouring blocks.

Top module: `plcp_framer`

## Requirements
- R1: While `rst` is high, and after it is released until a start is accepted, `tx_valid`, `tx_done` and `tx_bit` are 0.
- R2: With `short_pre`=0 the frame begins with 128 one bits, followed by the delimiter 16'hF3A0 sent bit 0 first.
- R3: With `short_pre`=1 the frame begins with 56 zero bits, followed by the delimiter 16'h05CF sent bit 0 first.
- R4: After the delimiter comes an 8-bit SIGNAL byte, sent bit 0 first, chosen by `rate`: 0 gives 8'h0A, 1 gives 8'h14, 2 gives 8'h37 and 3 gives 8'h6E.
- R5: After SIGNAL comes the 8-bit SERVICE byte (parameter, default 8'h00), then `length`; both are sent bit 0 first.
- R6: The last 16 bits carry a CRC computed over the 32 header bits in the order they are sent. The CRC uses the polynomial x^16+x^12+x^5+1, a register preset to all ones and a complemented result. Bit 15 of the complemented value is sent first.
- R7: Outputs change only on clock edges where `bit_en` is 1. The first bit appears on the first enable edge strictly after the edge that accepts the start. `tx_valid` then stays 1 for exactly 192 enables (long format) or 120 enables (short format).
- R8: On the enable edge after the last CRC bit, `tx_done` rises and `tx_valid` falls. `tx_done` falls on the next enable edge.
- R9: A start request is ignored from the edge that accepts a start until the enable edge that clears `tx_done`. The format, rate and length captured at acceptance stay in force for the whole frame.
- R10: Once `tx_done` has cleared, a new start request is accepted and produces a complete frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-clock enable; one bit per asserted cycle |
| start | input | 1 | Start request, sampled on every clock |
| short_pre | input | 1 | 1 selects the short format, 0 the long format |
| rate | input | 2 | Rate code for the SIGNAL byte |
| length | input | 16 | Value of the LENGTH field |
| tx_bit | output | 1 | Serial output bit |
| tx_valid | output | 1 | `tx_bit` carries a frame bit |
| tx_done | output | 1 | One-enable pulse after the last CRC bit |

## Verification
The bench builds the block with its default parameters. These are the full 128- and 56-bit sync runs, both delimiter values, SERVICE 8'h00 and the CCITT polynomial. Complete frames in both formats are therefore compared bit for bit against a model built from the requirements. Enables are spaced two idle cycles apart, which exposes any output that moves between enables. The bench also covers a start on the same edge as an enable, a start issued mid-frame or during the done pulse, and a reset in the middle of a frame.

// File: rtl/plcp_pkg.sv
package plcp_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_SYNC = 3'd1,
    PH_SFD  = 3'd2,
    PH_HDR  = 3'd3,
    PH_CRC  = 3'd4,
    PH_FIN  = 3'd5,
    PH_DONE = 3'd6
  } phase_e;

  localparam int SIG_W = 8;

  // rate code to SIGNAL byte
  function automatic logic [SIG_W-1:0] signal_code(input logic [1:0] rc);
    logic [SIG_W-1:0] s;
    case (rc)
      2'd0:    s = 8'h0A;
      2'd1:    s = 8'h14;
      2'd2:    s = 8'h37;
      default: s = 8'h6E;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/plcp_crc_ser.sv
module plcp_crc_ser #(
  parameter int               CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY  = 16'h1021
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init,
  input  logic             shift,
  input  logic             din,
  output logic [CRC_W-1:0] crc_o
);

  logic             fb;
  logic [CRC_W-1:0] nxt;

  always_comb begin
    fb  = din ^ crc_o[CRC_W-1];
    nxt = {crc_o[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & POLY);
  end

  always_ff @(posedge clk) begin
    if (rst || init) crc_o <= '1;
    else if (shift)  crc_o <= nxt;
  end

  // R6: the register is preset on every new frame
  assert_crc_preset_R6: assert property (@(posedge clk) disable iff (rst)
    init |=> (crc_o == '1));

endmodule

// File: rtl/plcp_seq.sv
module plcp_seq
  import plcp_pkg::*;
#(
  parameter int LONG_SYNC  = 128,
  parameter int SHORT_SYNC = 56,
  parameter int SFD_W      = 16,
  parameter int HDR_W      = 32,
  parameter int CRC_W      = 16,
  parameter int CNT_W      = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             accept,
  input  logic             short_sel,
  output phase_e           phase,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] last;
  logic             wrap;

  always_comb begin
    case (phase)
      PH_SYNC: last = short_sel ? CNT_W'(SHORT_SYNC - 1) : CNT_W'(LONG_SYNC - 1);
      PH_SFD:  last = CNT_W'(SFD_W - 1);
      PH_HDR:  last = CNT_W'(HDR_W - 1);
      PH_CRC:  last = CNT_W'(CRC_W - 1);
      default: last = '0;
    endcase
    wrap = (cnt == last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (accept) begin
      phase <= PH_SYNC;
      cnt   <= '0;
    end else if (bit_en) begin
      case (phase)
        PH_SYNC: begin
          if (wrap) begin phase <= PH_SFD; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        PH_SFD: begin
          if (wrap) begin phase <= PH_HDR; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        PH_HDR: begin
          if (wrap) begin phase <= PH_CRC; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        PH_CRC: begin
          if (wrap) begin phase <= PH_FIN; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        PH_FIN:  phase <= PH_DONE;
        PH_DONE: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R2/R3: the field counter never runs past its field
  assert_cnt_in_field_R2: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE) |-> (cnt <= last));

  // R7: the header is entered only from the delimiter field
  assert_hdr_after_sfd_R7: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HDR && $past(phase) != PH_HDR) |-> ($past(phase) == PH_SFD));

endmodule

// File: rtl/plcp_bit_sel.sv
module plcp_bit_sel
  import plcp_pkg::*;
#(
  parameter int               SFD_W     = 16,
  parameter int               HDR_W     = 32,
  parameter int               CRC_W     = 16,
  parameter int               CNT_W     = 7,
  parameter logic [SFD_W-1:0] LONG_SFD  = 16'hF3A0,
  parameter logic [SFD_W-1:0] SHORT_SFD = 16'h05CF,
  parameter logic             LONG_SYNC_BIT  = 1'b1,
  parameter logic             SHORT_SYNC_BIT = 1'b0
) (
  input  phase_e           phase,
  input  logic [CNT_W-1:0] cnt,
  input  logic             short_sel,
  input  logic [HDR_W-1:0] hdr_word,
  input  logic [CRC_W-1:0] crc_val,
  output logic             bit_o
);

  logic [SFD_W-1:0] sfd;
  logic             sfd_b, hdr_b, crc_b;

  always_comb begin
    sfd   = short_sel ? SHORT_SFD : LONG_SFD;
    sfd_b = 1'b0;
    hdr_b = 1'b0;
    crc_b = 1'b0;
    for (int i = 0; i < SFD_W; i++)
      if (cnt == CNT_W'(i)) sfd_b = sfd[i];
    for (int i = 0; i < HDR_W; i++)
      if (cnt == CNT_W'(i)) hdr_b = hdr_word[i];
    for (int i = 0; i < CRC_W; i++)
      if (cnt == CNT_W'(i)) crc_b = ~crc_val[CRC_W-1-i];
    case (phase)
      PH_SYNC: bit_o = short_sel ? SHORT_SYNC_BIT : LONG_SYNC_BIT;
      PH_SFD:  bit_o = sfd_b;
      PH_HDR:  bit_o = hdr_b;
      PH_CRC:  bit_o = crc_b;
      default: bit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/plcp_framer.sv
module plcp_framer
  import plcp_pkg::*;
#(
  parameter int               LONG_SYNC   = 128,
  parameter int               SHORT_SYNC  = 56,
  parameter int               SFD_W       = 16,
  parameter int               LEN_W       = 16,
  parameter int               SRV_W       = 8,
  parameter int               CRC_W       = 16,
  parameter logic [SFD_W-1:0] LONG_SFD    = 16'hF3A0,
  parameter logic [SFD_W-1:0] SHORT_SFD   = 16'h05CF,
  parameter logic [SRV_W-1:0] SERVICE_VAL = 8'h00,
  parameter logic [CRC_W-1:0] CRC_POLY    = 16'h1021
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             start,
  input  logic             short_pre,
  input  logic [1:0]       rate,
  input  logic [LEN_W-1:0] length,
  output logic             tx_bit,
  output logic             tx_valid,
  output logic             tx_done
);

  localparam int HDR_W     = SIG_W + SRV_W + LEN_W;
  localparam int SYNC_MAX  = (LONG_SYNC > SHORT_SYNC) ? LONG_SYNC : SHORT_SYNC;
  localparam int FIELD_MAX = (SYNC_MAX > HDR_W) ? SYNC_MAX : HDR_W;
  localparam int CNT_W     = $clog2(FIELD_MAX);
  localparam int LONG_BITS  = LONG_SYNC + SFD_W + HDR_W + CRC_W;
  localparam int SHORT_BITS = SHORT_SYNC + SFD_W + HDR_W + CRC_W;
  localparam int VB_W      = $clog2(LONG_BITS + 1);

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             accept;
  logic             cfg_short;
  logic [HDR_W-1:0] hdr_word;
  logic [CRC_W-1:0] crc_val;
  logic             sel_bit;

  assign accept = start && (phase == PH_IDLE);

  // capture of the frame configuration
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_short <= 1'b0;
      hdr_word  <= '0;
    end else if (accept) begin
      cfg_short <= short_pre;
      hdr_word  <= {length, SERVICE_VAL, signal_code(rate)};
    end
  end

  plcp_seq #(
    .LONG_SYNC (LONG_SYNC),
    .SHORT_SYNC(SHORT_SYNC),
    .SFD_W     (SFD_W),
    .HDR_W     (HDR_W),
    .CRC_W     (CRC_W),
    .CNT_W     (CNT_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .accept   (accept),
    .short_sel(cfg_short),
    .phase    (phase),
    .cnt      (cnt)
  );

  plcp_bit_sel #(
    .SFD_W    (SFD_W),
    .HDR_W    (HDR_W),
    .CRC_W    (CRC_W),
    .CNT_W    (CNT_W),
    .LONG_SFD (LONG_SFD),
    .SHORT_SFD(SHORT_SFD)
  ) u_sel (
    .phase    (phase),
    .cnt      (cnt),
    .short_sel(cfg_short),
    .hdr_word (hdr_word),
    .crc_val  (crc_val),
    .bit_o    (sel_bit)
  );

  plcp_crc_ser #(
    .CRC_W(CRC_W),
    .POLY (CRC_POLY)
  ) u_crc (
    .clk  (clk),
    .rst  (rst),
    .init (accept),
    .shift(bit_en && (phase == PH_HDR)),
    .din  (sel_bit),
    .crc_o(crc_val)
  );

  // registered serial outputs, moved only on bit enables
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_bit   <= 1'b0;
      tx_valid <= 1'b0;
      tx_done  <= 1'b0;
    end else if (bit_en) begin
      case (phase)
        PH_SYNC, PH_SFD, PH_HDR, PH_CRC: begin
          tx_bit   <= sel_bit;
          tx_valid <= 1'b1;
          tx_done  <= 1'b0;
        end
        PH_FIN: begin
          tx_bit   <= 1'b0;
          tx_valid <= 1'b0;
          tx_done  <= 1'b1;
        end
        default: begin
          tx_bit   <= 1'b0;
          tx_valid <= 1'b0;
          tx_done  <= 1'b0;
        end
      endcase
    end
  end

  // count of bits seen on the port, for the frame length check
  logic [VB_W-1:0] vbits;
  always_ff @(posedge clk) begin
    if (rst || accept)           vbits <= '0;
    else if (bit_en && tx_valid) vbits <= vbits + 1'b1;
  end

  // R1: reset clears the port
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!tx_valid && !tx_done && !tx_bit));

  // R7: nothing moves between bit enables
  assert_hold_between_en_R7: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> ($stable(tx_bit) && $stable(tx_valid) && $stable(tx_done)));

  // R7: full frame length per format
  assert_frame_len_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_done) |-> (vbits == (cfg_short ? VB_W'(SHORT_BITS) : VB_W'(LONG_BITS))));

  // R8: done lasts one enable and never overlaps valid
  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    (tx_done && bit_en) |=> !tx_done);
  assert_done_no_valid_R8: assert property (@(posedge clk) disable iff (rst)
    !(tx_done && tx_valid));

  // R9: a start while busy leaves the captured configuration alone
  assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (rst)
    (start && phase != PH_IDLE) |=> ($stable(hdr_word) && $stable(cfg_short)));

  // R6: the CRC is frozen while it is being sent
  assert_crc_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CRC) |=> $stable(crc_val));

endmodule

// File: tb/plcp_framer_test.sv
module plcp_framer_test;

  localparam int GAP = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_en = 1'b0;
  logic        start = 1'b0;
  logic        short_pre = 1'b0;
  logic [1:0]  rate = 2'd0;
  logic [15:0] length = 16'h0;
  logic        tx_bit, tx_valid, tx_done;

  int tests = 0;
  int fails = 0;
  int unstable = 0;
  logic exp_bits [0:255];
  int   exp_n;

  always #2 clk = ~clk;

  plcp_framer uut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .start(start),
    .short_pre(short_pre), .rate(rate), .length(length),
    .tx_bit(tx_bit), .tx_valid(tx_valid), .tx_done(tx_done)
  );

  // stimulus table: {short, rate, length, expected SIGNAL, expected bit count}
  localparam logic [34:0] VEC [6] = '{
    {1'b0, 2'd0, 16'h0000, 8'h0A, 8'd192},
    {1'b0, 2'd1, 16'h1234, 8'h14, 8'd192},
    {1'b0, 2'd2, 16'hFFFF, 8'h37, 8'd192},
    {1'b0, 2'd3, 16'h0801, 8'h6E, 8'd192},
    {1'b1, 2'd1, 16'h00A5, 8'h14, 8'd120},
    {1'b1, 2'd3, 16'h5A5A, 8'h6E, 8'd120}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic b);
    exp_bits[exp_n] = b;
    exp_n++;
  endtask

  // expected frame built from the requirements
  task automatic build(input logic sp, input logic [7:0] sig, input logic [15:0] ln);
    logic [15:0] sfd, crc;
    logic [31:0] hdr;
    logic        fb;
    exp_n = 0;
    for (int i = 0; i < (sp ? 56 : 128); i++) push(sp ? 1'b0 : 1'b1);
    sfd = sp ? 16'h05CF : 16'hF3A0;
    for (int i = 0; i < 16; i++) push(sfd[i]);
    hdr = {ln, 8'h00, sig};
    crc = 16'hFFFF;
    for (int i = 0; i < 32; i++) begin
      push(hdr[i]);
      fb  = hdr[i] ^ crc[15];
      crc = {crc[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    crc = ~crc;
    for (int i = 15; i >= 0; i--) push(crc[i]);
  endtask

  // one enable edge, then GAP idle cycles; outputs must hold over the gap
  task automatic step();
    logic b, v, d;
    @(negedge clk) bit_en = 1'b1;
    @(negedge clk) bit_en = 1'b0;
    b = tx_bit; v = tx_valid; d = tx_done;
    repeat (GAP) @(negedge clk);
    if (b !== tx_bit || v !== tx_valid || d !== tx_done) unstable++;
  endtask

  task automatic pulse_start(input logic sp, input logic [1:0] rt, input logic [15:0] ln);
    @(negedge clk);
    start = 1'b1; short_pre = sp; rate = rt; length = ln;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_frame(input logic sp, input logic [1:0] rt, input logic [15:0] ln,
                           input logic [7:0] sig, input int nb, input bit intrude, input bit poke);
    int idx, synclen, bad_pre, bad_sig, bad_hdr, bad_crc;
    bit got_done, prev_valid, done_after_last;
    string pre_tag;
    build(sp, sig, ln);
    synclen = sp ? 56 : 128;
    pre_tag = sp ? "R3 short sync/delimiter" : "R2 long sync/delimiter";
    unstable = 0; idx = 0; bad_pre = 0; bad_sig = 0; bad_hdr = 0; bad_crc = 0;
    got_done = 0; prev_valid = 0; done_after_last = 0;
    pulse_start(sp, rt, ln);
    short_pre = ~sp; rate = ~rt; length = ~ln;   // R9: later input changes must not matter
    check(tx_valid == 1'b0 && tx_done == 1'b0, "R7 no bit before first enable", {tx_valid, tx_done}, 0);
    for (int s = 0; s < 400 && !got_done; s++) begin
      step();
      if (tx_done) begin
        got_done = 1;
        done_after_last = prev_valid && (idx == nb);
        check(tx_valid == 1'b0, "R8 valid low with done", tx_valid, 0);
      end else if (tx_valid) begin
        if (idx >= nb || tx_bit !== exp_bits[idx]) begin
          if (idx < synclen + 16)      bad_pre++;
          else if (idx < synclen + 24) bad_sig++;
          else if (idx < synclen + 48) bad_hdr++;
          else                         bad_crc++;
        end
        idx++;
        if (intrude && idx == 40) pulse_start(~sp, rt + 2'd1, ~ln);   // R9
      end
      prev_valid = tx_valid;
    end
    check(bad_pre == 0, pre_tag, bad_pre, 0);
    check(bad_sig == 0, "R4 SIGNAL byte", bad_sig, 0);
    check(bad_hdr == 0, "R5 SERVICE and LENGTH", bad_hdr, 0);
    check(bad_crc == 0, "R6 header CRC", bad_crc, 0);
    check(idx == nb, "R7 valid bit count", idx, nb);
    check(got_done && done_after_last, "R8 done right after last CRC bit", {got_done, done_after_last}, 2'b11);
    if (intrude) check(bad_pre + bad_sig + bad_hdr + bad_crc == 0, "R9 mid-frame start ignored",
                       bad_pre + bad_sig + bad_hdr + bad_crc, 0);
    if (poke) pulse_start(1'b0, 2'd0, 16'h1111);  // start during the done pulse
    step();
    check(tx_done == 1'b0 && tx_valid == 1'b0, "R8 done lasts one enable", {tx_done, tx_valid}, 0);
    if (poke) begin
      step();
      check(tx_valid == 1'b0, "R9 start during done ignored", tx_valid, 0);
    end
    check(unstable == 0, "R7 outputs stable between enables", unstable, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog expired actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(tx_valid == 1'b0 && tx_done == 1'b0 && tx_bit == 1'b0, "R1 outputs during reset",
          {tx_valid, tx_done, tx_bit}, 0);
    rst = 1'b0;
    step(); step();
    check(tx_valid == 1'b0 && tx_done == 1'b0, "R1 idle without start", {tx_valid, tx_done}, 0);

    // table walk; frames run back to back (R10)
    for (int k = 0; k < 6; k++) begin
      run_frame(VEC[k][34], VEC[k][33:32], VEC[k][31:16], VEC[k][15:8], int'(VEC[k][7:0]),
                (k == 1 || k == 4), (k == 5));
    end

    // R10: new frame after a poked done pulse
    run_frame(1'b1, 2'd2, 16'hC3C3, 8'h37, 120, 1'b0, 1'b0);
    check(1'b1, "R10 frame after done accepted", 0, 0);

    // R7: start on the same edge as an enable
    @(negedge clk);
    start = 1'b1; bit_en = 1'b1; short_pre = 1'b0; rate = 2'd3; length = 16'h0007;
    @(negedge clk);
    start = 1'b0; bit_en = 1'b0;
    check(tx_valid == 1'b0, "R7 no bit on the accepting edge", tx_valid, 0);
    step();
    check(tx_valid == 1'b1 && tx_bit == 1'b1, "R7 first long sync bit", {tx_valid, tx_bit}, 2'b11);

    // R1: reset in mid frame
    step();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    check(tx_valid == 1'b0 && tx_done == 1'b0, "R1 reset mid-frame", {tx_valid, tx_done}, 0);
    step();
    check(tx_valid == 1'b0, "R1 idle after mid-frame reset", tx_valid, 0);

    // R10: a full short frame after reset
    run_frame(1'b1, 2'd0, 16'h0100, 8'h0A, 120, 1'b0, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule